// File: doc/BRIEF.md
# Packed Signed 16-bit Lane Multiplier with Pairwise Accumulate

This block multiplies two 64-bit operands lane by lane. Each operand carries four signed 16-bit lanes. Lane i of the first operand is multiplied by lane i of the second, which gives four 32-bit two's complement products.

A 2-bit mode input selects one of three ways to pack those products into a single 64-bit result:

- the lower 16 bits of every product;
- the upper 16 bits of every product;
- two 32-bit sums, each formed from a pair of neighbouring products.

The last form is the basic step of a dot product or a filter tap.

The unit has a fixed two-stage pipeline and accepts a new operand set on every cycle. A result and its valid flag come out two clock edges after the input strobe. When no result is produced, the output word keeps its last value.

Top module: `pmul16x4`

## Requirements
- R1: `out_vld` is high in exactly the cycles that follow, by two rising clock edges, a cycle in which `in_vld` was high. Inputs presented on consecutive cycles each produce a result on consecutive cycles.
- R2: With mode 00, result bits [16i+15:16i] equal bits [15:0] of the product of lane i of `in_a` and lane i of `in_b`, for i = 0..3. Lane i of an operand is bits [16i+15:16i].
- R3: With mode 01, result bits [16i+15:16i] equal bits [31:16] of the 32-bit signed product of lane i of `in_a` and lane i of `in_b`.
- R4: With mode 10, result bits [63:32] equal a3*b3 + a2*b2 and result bits [31:0] equal a1*b1 + a0*b0, where ai and bi are the signed lanes.
- R5: Lane values are treated as signed two's complement. For example, FFFFh times 0002h has a high half of FFFFh and a low half of FFFEh.
- R6: In mode 10, each pair sum is kept modulo 2^32. When all four inputs of a pair are 8000h, that half of the result is 80000000h.
- R7: Mode 11 is reserved and gives an all-zero result.
- R8: A cycle without a result leaves `out_res` unchanged from the last result.
- R9: During and right after reset, `out_vld` is 0 and `out_res` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input operand strobe |
| in_mode | input | 2 | 00 low halves, 01 high halves, 10 pair sums, 11 reserved |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_vld | output | 1 | Result valid, two cycles after `in_vld` |
| out_res | output | 64 | Packed result |

## Verification
Random 64-bit operands with random modes and gaps in the strobe check that lanes do not mix and that results line up with the right input cycle. Directed vectors cover several cases, each of which separates a correct design from a typical mistake:

- Operands of mixed sign separate a signed multiply from an unsigned one.
- Operands with ones in the upper lane bits reveal swapped low and high halves.
- Pairs made entirely of 8000h confirm the wrap of the pair sum.
- Runs of back-to-back strobes, and idle gaps between strobes, expose errors in the valid timing and in the hold behaviour.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
   typedef enum logic [1:0] {
      MODE_LO  = 2'b00,
      MODE_HI  = 2'b01,
      MODE_MAC = 2'b10,
      MODE_RSV = 2'b11
   } pm_mode_e;
endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   if (W < 2) begin : g_bad_w
      $error("pmul_lane: W must be at least 2");
   end

   logic [PW-1:0] ax, bx, p_c;

   always_comb begin
      ax  = {{W{a[W-1]}}, a};
      bx  = {{W{b[W-1]}}, b};
      p_c = ax * bx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  prod <= '0;
      else if (en) prod <= p_c;
   end
endmodule

// File: rtl/pmul_select.sv
module pmul_select #(
   parameter int W     = 16,
   parameter int LANES = 4,
   parameter bit MAC_EN = 1'b1
) (
   input  logic [1:0]           mode,
   input  logic [LANES*2*W-1:0] prods,
   output logic [LANES*W-1:0]   res
);
   import pmul_pkg::*;
   localparam int PW = 2 * W;
   localparam int DW = LANES * W;
   localparam int NP = LANES / 2;

   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("pmul_select: LANES must be even");
   end

   logic [DW-1:0] lo_v, hi_v, mac_v;

   for (genvar i = 0; i < LANES; i++) begin : g_half
      assign lo_v[i*W +: W] = prods[i*PW     +: W];
      assign hi_v[i*W +: W] = prods[i*PW + W +: W];
   end

   if (MAC_EN) begin : g_mac
      for (genvar k = 0; k < NP; k++) begin : g_pair
         assign mac_v[k*PW +: PW] = prods[(2*k)*PW +: PW] + prods[(2*k+1)*PW +: PW];
      end
   end else begin : g_nomac
      assign mac_v = '0;
   end

   always_comb begin
      unique case (pm_mode_e'(mode))
         MODE_LO:  res = lo_v;
         MODE_HI:  res = hi_v;
         MODE_MAC: res = mac_v;
         default:  res = '0;
      endcase
   end
endmodule

// File: rtl/pmul16x4.sv
module pmul16x4 #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic [1:0]              in_mode,
   input  logic [LANE_W*LANES-1:0] in_a,
   input  logic [LANE_W*LANES-1:0] in_b,
   output logic                    out_vld,
   output logic [LANE_W*LANES-1:0] out_res
);
   import pmul_pkg::*;
   localparam int DW = LANE_W * LANES;
   localparam int PW = 2 * LANE_W;

   if (LANES < 2 || LANES % 2 != 0) begin : g_bad_cfg
      $error("pmul16x4: LANES must be even and at least 2");
   end

   logic          s1_vld;
   logic [1:0]    s1_mode;
   logic [LANES*PW-1:0] prods;
   logic [DW-1:0] sel_res;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pmul_lane #(.W(LANE_W)) u_lane (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (in_vld),
         .a    (in_a[i*LANE_W +: LANE_W]),
         .b    (in_b[i*LANE_W +: LANE_W]),
         .prod (prods[i*PW +: PW])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_mode <= 2'b00;
      end else begin
         s1_vld  <= in_vld;
         if (in_vld) s1_mode <= in_mode;
      end
   end

   pmul_select #(.W(LANE_W), .LANES(LANES), .MAC_EN(1'b1)) u_sel (
      .mode (s1_mode),
      .prods(prods),
      .res  (sel_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_res <= '0;
      end else begin
         out_vld <= s1_vld;
         if (s1_vld) out_res <= sel_res;
      end
   end

   // R1
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld |=> out_vld);
   // R1
   vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_vld |=> !out_vld);
   // R7
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_mode == 2'b11) |=> (out_res == '0));
   // R8
   hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_vld |=> $stable(out_res));
   // R2
   lo_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_mode == 2'b00) |=> (out_res[LANE_W-1:0] == $past(prods[LANE_W-1:0])));
endmodule

// File: tb/sim_pmul16x4.sv
`timescale 1ns/100ps
module sim_pmul16x4;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [1:0]  in_mode = 2'b00;
   logic [63:0] in_a = '0, in_b = '0;
   logic        out_vld;
   logic [63:0] out_res;

   int total = 0, bad = 0;
   bit done = 1'b0;

   logic        hv0 = 1'b0, hv1 = 1'b0;
   logic [63:0] hr0 = '0, hr1 = '0, last_res = '0;
   string       ht0 = "R1", ht1 = "R1";

   always #2.5 clk = ~clk;

   pmul16x4 u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
                .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_res(out_res));

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] m);
      logic signed [31:0] p [4];
      logic [63:0] r;
      for (int i = 0; i < 4; i++)
         p[i] = 32'($signed(a[16*i +: 16])) * 32'($signed(b[16*i +: 16]));
      r = '0;
      case (m)
         2'b00: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
         2'b01: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
         2'b10: begin
            r[31:0]  = 32'(p[0] + p[1]);
            r[63:32] = 32'(p[2] + p[3]);
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [1:0] m);
      case (m)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] m, input logic [63:0] a,
                       input logic [63:0] b, input string req_over = "");
      @(negedge clk);
      check("R1", {63'd0, out_vld}, {63'd0, hv1});
      if (hv1) begin
         last_res = hr1;
         check(ht1, out_res, last_res);
      end else begin
         check("R8", out_res, last_res);
      end
      hv1 = hv0; hr1 = hr0; ht1 = ht0;
      hv0 = v;   hr0 = model(a, b, m);
      ht0 = (req_over != "") ? req_over : tag_of(m);
      in_vld = v; in_mode = m; in_a = a; in_b = b;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", {63'd0, out_vld}, 64'd0);
      check("R9", out_res, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", {63'd0, out_vld}, 64'd0);
      check("R9", out_res, 64'd0);

      // R5: signed lanes, FFFF*0002
      step(1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0002_0002_0002_0002, "R5");
      step(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0002_0002_0002_0002, "R5");
      step(1, 2'b01, 64'h8000_7FFF_8000_1234, 64'h8000_7FFF_7FFF_FEDC);
      step(1, 2'b00, 64'h8000_7FFF_8000_1234, 64'h8000_7FFF_7FFF_FEDC);
      step(1, 2'b10, 64'h0003_0004_FFFE_0005, 64'h0002_FFFF_0006_0007);
      // R6: wrap of pair sums
      step(1, 2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R6");
      step(1, 2'b10, 64'h8000_8000_0001_0001, 64'h8000_8000_0001_0001, "R6");
      // R7: reserved mode, then gaps for R8
      step(1, 2'b11, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444);
      step(0, 2'b00, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_0000_FFFF_0000);
      step(1, 2'b00, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF);
      step(0, 2'b10, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA);
      step(0, 2'b01, 64'h0, 64'h0);
      step(0, 2'b01, 64'h0, 64'h0);

      // random mix (R1..R4, R7, R8)
      for (int n = 0; n < 400; n++) begin
         logic v;
         logic [1:0] m;
         v = ($urandom % 4) != 0;
         m = 2'($urandom % 4);
         step(v, m, {$urandom, $urandom}, {$urandom, $urandom});
      end
      for (int n = 0; n < 4; n++) step(0, 2'b00, 64'h0, 64'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule